// File: doc/BRIEF.md
# Cycle-Stealing DMA Engine

A single-channel engine that moves a block of words between a peripheral and system memory without the processor copying any data. Software writes a device address, a memory start address, a word count and a direction into four small registers, then sets the start bit. From then on the engine works by itself. It borrows the system bus for one cycle per word and gives it straight back. The processor is held off only for that one bus cycle, and it takes no interrupt and switches no context when this happens.

The DMA logic sits on the I/O side of the bus. Each word therefore crosses the system bus once, as one memory access: the device word is written to memory, or the memory word is handed to the device in that same cycle. The engine asks for the bus only when the device can take part in a transfer, meaning it holds a word or has room for one. When the last word is done, the engine raises an interrupt line. That line stays high until software clears it.

Top module: `cs_dma_engine`

## Requirements
- R1: Register port, selected by `cfg_addr`:
  - 0 is control/status. A write with bit 0 set starts a transfer, and bit 1 of that write selects the direction (1 = memory to device, 0 = device to memory). A write with bit 2 set clears the done flag. A read returns bit 0 = busy, bit 1 = direction, bit 2 = done.
  - 1 is the device address, which is driven on `dev_addr`.
  - 2 is the current memory address.
  - 3 is the remaining word count.
  - All registers reset to zero.
- R2: While waiting for a word, `bus_req` is asserted only in cycles where `dev_ready` is high.
- R3: `mem_en` and `dev_strobe` are asserted only in a cycle after a grant was sampled, and only while both `bus_req` and `bus_gnt` are high.
- R4: Each grant moves exactly one word. In the cycle after any word transfer, `bus_req` and `mem_en` are both low.
- R5: Device to memory: `mem_we` is 1 and `mem_wdata` equals `dev_rdata`. Memory to device: `mem_we` is 0 and `dev_wdata` equals `mem_rdata`. In both directions `dev_strobe` pulses in the same cycle as `mem_en`.
- R6: Each word increments the memory address by one and decrements the count by one, and both values can be read back. Successive words use consecutive addresses from the programmed start.
- R7: After the last word, done reads 1, busy reads 0 and `irq` is high. `irq` stays high until a control write with bit 2 set, after which it is low on the next cycle.
- R8: While busy, writes to any register are ignored. This includes a start write that lands in the same cycle as the final word.
- R9: A start with a count of zero sets done and `irq` on the next cycle and never asserts `bus_req`.
- R10: An accepted start clears a done flag left from an earlier transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_sel | input | 1 | Register access strobe |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | 2 | Register index |
| cfg_wdata | input | REG_W | Register write data |
| cfg_rdata | output | REG_W | Register read data (combinational) |
| bus_req | output | 1 | System bus request |
| bus_gnt | input | 1 | System bus grant |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data (same cycle) |
| dev_addr | output | DEV_W | Programmed device address |
| dev_ready | input | 1 | Device holds a word, or has room for one |
| dev_strobe | output | 1 | Word taken from, or given to, the device |
| dev_rdata | input | DATA_W | Word from the device |
| dev_wdata | output | DATA_W | Word to the device |
| irq | output | 1 | Transfer-complete interrupt |

## Verification
Two events can fall in the same cycle: the transfer of the final word, and a processor write to the control register carrying the start bit. The bench provokes this by watching for the cycle in which `mem_en` is high and one word remains, and it drives the start write in exactly that cycle. The outcome is judged at the ports. The start must be ignored, so afterwards busy must read 0, done and `irq` must be 1, the address and count must show only the original transfer, and `bus_req` must stay low.

// File: rtl/cs_dma_pkg.sv
// Shared definitions for the cycle-stealing DMA engine.
// Assumes a two-bit register index on the processor port.
package cs_dma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_XFER = 2'd2,
        ST_REL  = 2'd3
    } dma_state_e;

    localparam logic [1:0] RA_CTRL = 2'd0;
    localparam logic [1:0] RA_DEV  = 2'd1;
    localparam logic [1:0] RA_MEM  = 2'd2;
    localparam logic [1:0] RA_CNT  = 2'd3;

    localparam int CB_GO  = 0;
    localparam int CB_DIR = 1;
    localparam int CB_CLR = 2;

endpackage

// File: rtl/cs_dma_regs.sv
// Register bank: holds the programmed direction, device address, the live
// memory address and remaining count, and the done flag.
// Assumes REG_W is at least as wide as ADDR_W, DEV_W and CNT_W.
// Writes are accepted only while the sequencer is idle.
module cs_dma_regs
    import cs_dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DEV_W  = 8,
    parameter int CNT_W  = 16,
    parameter int REG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_sel,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              busy,
    input  logic              xfer,
    input  logic              finish,
    output logic              start_acc,
    output logic              dir,
    output logic [DEV_W-1:0]  dev_addr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              cnt_zero,
    output logic              cnt_one,
    output logic              done
);

    logic             wr;
    logic             cfg_open;
    logic             clr_req;
    logic [CNT_W-1:0] cnt_q;

    // Decode a write and whether it may touch the configuration.
    always_comb begin
        wr        = cfg_sel && cfg_we;
        cfg_open  = wr && !busy;
        start_acc = cfg_open && (cfg_addr == RA_CTRL) && cfg_wdata[CB_GO];
        clr_req   = wr && (cfg_addr == RA_CTRL) && cfg_wdata[CB_CLR];
        cnt_zero  = (cnt_q == '0);
        cnt_one   = (cnt_q == CNT_W'(1));
    end

    // Read multiplexer, zero-extended to the port width.
    always_comb begin
        case (cfg_addr)
            RA_CTRL: cfg_rdata = REG_W'({done, dir, busy});
            RA_DEV:  cfg_rdata = REG_W'(dev_addr);
            RA_MEM:  cfg_rdata = REG_W'(mem_addr);
            default: cfg_rdata = REG_W'(cnt_q);
        endcase
    end

    // Configuration registers, plus the per-word address and count step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir      <= 1'b0;
            dev_addr <= '0;
            mem_addr <= '0;
            cnt_q    <= '0;
        end else begin
            if (start_acc)
                dir <= cfg_wdata[CB_DIR];
            if (cfg_open && cfg_addr == RA_DEV)
                dev_addr <= cfg_wdata[DEV_W-1:0];
            if (cfg_open && cfg_addr == RA_MEM)
                mem_addr <= cfg_wdata[ADDR_W-1:0];
            if (cfg_open && cfg_addr == RA_CNT)
                cnt_q <= cfg_wdata[CNT_W-1:0];
            if (xfer) begin
                mem_addr <= mem_addr + 1'b1;
                cnt_q    <= cnt_q - 1'b1;
            end
        end
    end

    // Done flag: completion sets it; a clear or a new start drops it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done <= 1'b0;
        else if (finish)
            done <= 1'b1;
        else if (start_acc || clr_req)
            done <= 1'b0;
    end

endmodule

// File: rtl/cs_dma_seq.sv
// Transfer sequencer: waits for the device, requests the bus, moves one word
// per grant, then drops the request for one cycle before asking again.
// Assumes the arbiter keeps the grant high for as long as the request is high,
// and that the device keeps dev_ready high until it is strobed.
module cs_dma_seq
    import cs_dma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_acc,
    input  logic cnt_zero,
    input  logic cnt_one,
    input  logic dev_ready,
    input  logic bus_gnt,
    output logic busy,
    output logic bus_req,
    output logic xfer,
    output logic finish
);

    dma_state_e st_q;
    dma_state_e st_d;

    // Next-state choice for the one-word-per-grant cycle.
    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE: if (start_acc && !cnt_zero) st_d = ST_WAIT;
            ST_WAIT: if (dev_ready && bus_gnt)   st_d = ST_XFER;
            ST_XFER: st_d = cnt_one ? ST_IDLE : ST_REL;
            ST_REL:  st_d = ST_WAIT;
            default: st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= ST_IDLE;
        else
            st_q <= st_d;
    end

    // Outputs decoded from the state.
    always_comb begin
        busy    = (st_q != ST_IDLE);
        xfer    = (st_q == ST_XFER);
        bus_req = ((st_q == ST_WAIT) && dev_ready) || xfer;
        finish  = (start_acc && cnt_zero) || (xfer && cnt_one);
    end

endmodule

// File: rtl/cs_dma_route.sv
// Data routing for a single-pass word: the device word goes to the memory
// write bus, or the memory read word goes to the device, in one cycle.
// Assumes memory read data is valid in the same cycle as the address.
module cs_dma_route #(
    parameter int DATA_W = 16
) (
    input  logic              dir,
    input  logic              xfer,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] dev_rdata,
    output logic              mem_en,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] dev_wdata,
    output logic              dev_strobe
);

    // Strobes and data paths for the word being moved this cycle.
    always_comb begin
        mem_en     = xfer;
        mem_we     = xfer && !dir;
        dev_strobe = xfer;
        mem_wdata  = dev_rdata;
        dev_wdata  = mem_rdata;
    end

endmodule

// File: rtl/cs_dma_engine.sv
// Top level of the single-channel cycle-stealing DMA engine.
// Connects the register bank, the sequencer and the data routing.
// Assumes one word moves per bus grant and memory answers in the same cycle.
module cs_dma_engine #(
    parameter int ADDR_W = 16,
    parameter int DEV_W  = 8,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16,
    parameter int REG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_sel,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DEV_W-1:0]  dev_addr,
    input  logic              dev_ready,
    output logic              dev_strobe,
    input  logic [DATA_W-1:0] dev_rdata,
    output logic [DATA_W-1:0] dev_wdata,
    output logic              irq
);

    logic busy;
    logic xfer;
    logic finish;
    logic start_acc;
    logic dir;
    logic cnt_zero;
    logic cnt_one;
    logic done;

    cs_dma_regs #(
        .ADDR_W(ADDR_W),
        .DEV_W (DEV_W),
        .CNT_W (CNT_W),
        .REG_W (REG_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_sel  (cfg_sel),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata),
        .busy     (busy),
        .xfer     (xfer),
        .finish   (finish),
        .start_acc(start_acc),
        .dir      (dir),
        .dev_addr (dev_addr),
        .mem_addr (mem_addr),
        .cnt_zero (cnt_zero),
        .cnt_one  (cnt_one),
        .done     (done)
    );

    cs_dma_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_acc(start_acc),
        .cnt_zero (cnt_zero),
        .cnt_one  (cnt_one),
        .dev_ready(dev_ready),
        .bus_gnt  (bus_gnt),
        .busy     (busy),
        .bus_req  (bus_req),
        .xfer     (xfer),
        .finish   (finish)
    );

    cs_dma_route #(
        .DATA_W(DATA_W)
    ) u_route (
        .dir       (dir),
        .xfer      (xfer),
        .mem_rdata (mem_rdata),
        .dev_rdata (dev_rdata),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .dev_wdata (dev_wdata),
        .dev_strobe(dev_strobe)
    );

    // The interrupt line mirrors the done flag.
    always_comb irq = done;

endmodule

// File: rtl/cs_dma_checker.sv
// Protocol checker for the DMA engine, bound to the top module.
// Watches only the ports; holds no model of the transfer.
module cs_dma_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_sel,
    input logic              cfg_we,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic              mem_en,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              dev_ready,
    input logic              dev_strobe,
    input logic              irq
);

    // R2: a new request appears only when the device can take part.
    a_r2_req_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> dev_ready);

    // R3: the bus is driven only while it is requested and granted.
    a_r3_drive_granted: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en || dev_strobe) |-> (bus_gnt && bus_req));

    // R4: after every word the bus is released for at least a cycle.
    a_r4_one_word: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |=> (!mem_en && !bus_req));

    // R6: the next memory address follows the one just used.
    a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |=> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

    // R7: the interrupt rises only after a word or a register write.
    a_r7_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(mem_en) || $past(cfg_sel && cfg_we)));

    // R7: no interrupt is raised while words are still moving.
    a_r7_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> !irq);

endmodule

bind cs_dma_engine cs_dma_checker #(
    .ADDR_W(ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_sel   (cfg_sel),
    .cfg_we    (cfg_we),
    .bus_req   (bus_req),
    .bus_gnt   (bus_gnt),
    .mem_en    (mem_en),
    .mem_addr  (mem_addr),
    .dev_ready (dev_ready),
    .dev_strobe(dev_strobe),
    .irq       (irq)
);

// File: tb/cs_dma_engine_tb.sv
// Self-checking bench: directed corner cases plus seeded random transfers,
// with random device readiness and random grant latency.
module cs_dma_engine_tb;

    logic        clk;
    logic        rst_n;
    logic        cfg_sel;
    logic        cfg_we;
    logic [1:0]  cfg_addr;
    logic [15:0] cfg_wdata;
    logic [15:0] cfg_rdata;
    logic        bus_req;
    logic        bus_gnt;
    logic        mem_en;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic [7:0]  dev_addr;
    logic        dev_ready;
    logic        dev_strobe;
    logic [15:0] dev_rdata;
    logic [15:0] dev_wdata;
    logic        irq;

    logic [15:0] mem_model [256];
    int          dev_idx;
    int          checks;
    int          errs;
    int          cyc;
    int          words;
    int          exp_addr;
    int          exp_cnt;
    bit          cur_dir;
    bit          last_x;
    bit          saw_req;
    bit          ready_on;
    bit          collide_arm;
    logic [15:0] rd_cap;
    bit          p_sel;
    bit          p_we;
    logic [1:0]  p_addr;
    logic [15:0] p_data;

    function automatic logic [15:0] src_word(int k);
        return 16'((k * 97 + 16'h1234) ^ (k << 5));
    endfunction

    assign mem_rdata = mem_model[mem_addr[7:0]];
    assign dev_rdata = src_word(dev_idx);

    cs_dma_engine u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .dev_addr(dev_addr), .dev_ready(dev_ready), .dev_strobe(dev_strobe),
        .dev_rdata(dev_rdata), .dev_wdata(dev_wdata), .irq(irq)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    // One clock: apply pending register access, drive device and grant, then sample.
    task automatic cycle();
        @(negedge clk);
        cyc++;
        if (cyc > 150000) begin
            chk(1'b0, "watchdog", cyc, 150000);
            finish_run();
        end
        cfg_sel = p_sel; cfg_we = p_we; cfg_addr = p_addr; cfg_wdata = p_data;
        p_sel = 1'b0; p_we = 1'b0;
        if (!bus_req)
            dev_ready = ready_on && ($urandom % 4 != 0);
        #1;
        if (!bus_req)
            bus_gnt = 1'b0;
        else if (!bus_gnt)
            bus_gnt = ($urandom % 3 != 0);
        if (collide_arm && mem_en && words == exp_cnt - 1) begin
            // Final word moving now: issue a start write in this same cycle (R8).
            cfg_sel = 1'b1; cfg_we = 1'b1; cfg_addr = 2'd0;
            cfg_wdata = 16'h0001 | (cur_dir ? 16'h0000 : 16'h0002);
            collide_arm = 1'b0;
        end
        #2;
        rd_cap = cfg_rdata;
        if (bus_req) saw_req = 1'b1;
        if (last_x) begin
            chk(!bus_req && !mem_en, "R4 bus released after word", int'(bus_req), 0);
            last_x = 1'b0;
        end
        if (mem_en) begin
            chk(bus_gnt && bus_req && dev_strobe, "R3 drive only with grant",
                int'({bus_req, bus_gnt, dev_strobe}), 7);
            chk(int'(mem_addr) == exp_addr, "R6 consecutive address", int'(mem_addr), exp_addr);
            if (!cur_dir) begin
                chk(mem_we && mem_wdata == src_word(dev_idx), "R5 device to memory word",
                    int'(mem_wdata), int'(src_word(dev_idx)));
                mem_model[mem_addr[7:0]] = mem_wdata;
            end else begin
                chk(!mem_we && dev_wdata == mem_model[8'(exp_addr)], "R5 memory to device word",
                    int'(dev_wdata), int'(mem_model[8'(exp_addr)]));
            end
            dev_idx++;
            exp_addr++;
            words++;
            last_x = 1'b1;
        end
    endtask

    task automatic cpu_write(logic [1:0] a, logic [15:0] d);
        p_sel = 1'b1; p_we = 1'b1; p_addr = a; p_data = d;
        cycle();
    endtask

    task automatic cpu_read(logic [1:0] a, output logic [15:0] v);
        p_sel = 1'b1; p_we = 1'b0; p_addr = a; p_data = 16'h0;
        cycle();
        v = rd_cap;
    endtask

    // mode 0: normal, 1: writes while busy, 2: start in the final-word cycle.
    task automatic run_xfer(bit dir, int dev, int maddr, int cnt, int mode);
        logic [15:0] v;
        cpu_write(2'd1, 16'(dev));
        cpu_write(2'd2, 16'(maddr));
        cpu_write(2'd3, 16'(cnt));
        words = 0; exp_addr = maddr; cur_dir = dir; exp_cnt = cnt;
        last_x = 1'b0; saw_req = 1'b0;
        ready_on = (mode != 1);
        collide_arm = (mode == 2);
        cpu_write(2'd0, 16'h0001 | (dir ? 16'h0002 : 16'h0000));
        cycle();
        if (cnt == 0) begin
            chk(irq == 1'b1, "R9 zero count completes at once", int'(irq), 1);
        end else begin
            chk(irq == 1'b0, "R10 start clears earlier done", int'(irq), 0);
        end
        if (mode == 1) begin
            cpu_write(2'd2, 16'h00AA);
            cpu_write(2'd3, 16'h0009);
            cpu_write(2'd0, 16'h0001 | (dir ? 16'h0000 : 16'h0002));
            ready_on = 1'b1;
        end
        for (int n = 0; n < 3000 && !irq; n++) cycle();
        cycle();
        chk(words == cnt, "R6 word total", words, cnt);
        if (cnt == 0) chk(!saw_req, "R9 no bus request on zero count", int'(saw_req), 0);
        saw_req = 1'b0;
        cpu_read(2'd3, v);
        chk(v == 16'h0, "R6 count exhausted", int'(v), 0);
        cpu_read(2'd2, v);
        chk(v == 16'(maddr + cnt), "R6 R8 final memory address", int'(v), maddr + cnt);
        cpu_read(2'd0, v);
        chk(v == (16'h0004 | (dir ? 16'h0002 : 16'h0000)), "R1 R7 R8 status after done",
            int'(v), int'(16'h0004 | (dir ? 16'h0002 : 16'h0000)));
        chk(dev_addr == 8'(dev), "R1 device address output", int'(dev_addr), dev);
        chk(!saw_req && irq, "R7 R8 idle with irq held", int'({saw_req, irq}), 1);
    endtask

    initial begin
        logic [15:0] v;
        void'($urandom(32'd20240611));
        checks = 0; errs = 0; cyc = 0; dev_idx = 0; words = 0;
        exp_addr = 0; exp_cnt = 0; cur_dir = 0; last_x = 0; saw_req = 0;
        ready_on = 0; collide_arm = 0;
        p_sel = 0; p_we = 0; p_addr = 0; p_data = 0;
        cfg_sel = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
        bus_gnt = 0; dev_ready = 0; rst_n = 0;
        for (int i = 0; i < 256; i++) mem_model[i] = 16'(i * 3 + 1);
        repeat (3) cycle();
        rst_n = 1;
        cycle();
        chk(!irq && !bus_req && !mem_en, "R1 reset outputs idle",
            int'({irq, bus_req, mem_en}), 0);
        cpu_read(2'd0, v);
        chk(v == 16'h0, "R1 reset control", int'(v), 0);
        cpu_read(2'd3, v);
        chk(v == 16'h0, "R1 reset count", int'(v), 0);

        run_xfer(1'b0, 8'h3C, 16, 5, 0);    // R5 device to memory
        run_xfer(1'b1, 8'h41, 16, 4, 0);    // R5 memory to device, reads back words
        cpu_write(2'd0, 16'h0004);
        cycle();
        chk(irq == 1'b0, "R7 clear drops irq", int'(irq), 0);
        run_xfer(1'b0, 8'h07, 40, 0, 0);    // R9 zero count
        run_xfer(1'b1, 8'h55, 60, 4, 1);    // R8 writes while busy
        run_xfer(1'b0, 8'h66, 90, 3, 2);    // R8 start in final-word cycle
        run_xfer(1'b1, 8'h12, 200, 1, 2);   // R8 collision on a single word

        for (int t = 0; t < 24; t++) begin
            run_xfer(1'($urandom % 2), int'($urandom % 256), int'($urandom % 200),
                     1 + int'($urandom % 12), 0);
            if ($urandom % 2 == 1) begin
                cpu_write(2'd0, 16'h0004);
                cycle();
                chk(irq == 1'b0, "R7 clear drops irq", int'(irq), 0);
            end
        end
        finish_run();
    end

endmodule